// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block is the target side of a two-wire serial bus in front of a 256-byte store. A bus master selects it with a seven-bit address. The upper four bits of that address are fixed at 1010. The lower three bits come from strap inputs, so up to eight copies can share one bus. The master can write one byte or a short burst that stays inside a four-byte page. It can read from the current pointer, from an address it chose just before, or as a continuous stream.

SCL and SDA come in already sampled by the system clock and pass through a synchroniser. The block drives SDA through an open-drain enable, where 1 means pull the line low. Bytes the master writes are held in a page buffer. They reach the store only when the stop condition arrives. The stop then starts a write cycle whose length is a count of clocks. While that cycle runs the busy output is high and the block does not respond to its address. A write-inhibit input blocks stores while it is high.

Top module: `i2c_mem_slave`

## Requirements
- R1: The first byte after a start is taken as address bits [7:1] and a direction bit [0], where 1 means read. The block pulls SDA low in the ninth clock only when bits [7:1] equal {1010, strap_i}. For any other address it leaves SDA released until the next start.
- R2: In a write, the byte after the address sets the word pointer. Every byte after that is data. The block acknowledges the word-pointer byte and each data byte.
- R3: After each accepted data byte only the two low pointer bits advance, and the upper bits stay as they are. A fifth byte in the same transfer lands in the slot of the first byte and replaces it.
- R4: Buffered bytes reach the store only on a stop condition. A repeated start throws the buffer away, and the store keeps its old contents.
- R5: A stop that commits at least one byte raises busy_o on the third rising clock edge after SDA rises. busy_o then stays high for exactly WRITE_CLKS clocks. At all other times busy_o is low.
- R6: While busy_o is high the block does not acknowledge its address byte, whether the direction bit asks for a read or a write.
- R7: While wr_inhibit_i is high, data bytes are still acknowledged but are dropped. The pointer does not move, and the following stop starts no write cycle.
- R8: After a page commits, the pointer points one past the last byte written, counting within the page and wrapping inside it.
- R9: A read sends the byte at the pointer, most significant bit first. The pointer then advances by one.
- R10: A word-pointer write followed by a repeated start with the direction bit set to read returns the byte at that word address.
- R11: Each master acknowledge after a read byte causes the next byte to be sent, and the pointer wraps from 255 to 0. After a master non-acknowledge the block releases SDA and waits for a stop or a start.
- R12: After reset SDA is released, busy_o is low, the pointer is 0 and every stored byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| strap_i | input | 3 | Low three address bits from board straps |
| wr_inhibit_i | input | 1 | High blocks writes to the store |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
The hardest case to reach is an address byte that arrives while a write cycle is still running. The bench therefore makes the write cycle long enough that a fresh start and address byte, issued right after a committing stop, finish inside the busy window and must be refused. A second awkward case is a write buffer thrown away by a repeated start. The bench writes a byte, turns the transfer around into a read without a stop, and then reads the target address back to show that nothing was stored. A reference model in the bench tracks the busy window clock by clock. It also tracks the pointer inside the page across six-byte bursts.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;
    localparam int BYTE_W = 8;
    // Fixed upper nibble of the target address
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_WORD,
        PH_WORD_ACK,
        PH_WR,
        PH_WR_ACK,
        PH_RD,
        PH_RD_ACK
    } phase_e;

    // Line events seen after synchronisation
    typedef struct packed {
        logic scl_hi;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic start;
        logic stop;
        logic inhibit;
    } bus_ev_t;
endpackage

// File: rtl/i2c_mem_sync.sv
`timescale 1ns/1ps
module i2c_mem_sync
    import i2c_mem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    input  logic    inhibit_i,
    output bus_ev_t ev_o
);
    // [0] first stage, [1] settled value, [2] value one clock earlier
    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
        logic [1:0] inh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[1:0], scl_i};
        s_d.sda = {s_q.sda[1:0], sda_i};
        s_d.inh = {s_q.inh[0], inhibit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{scl: 3'b111, sda: 3'b111, inh: 2'b11};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ev_o.scl_hi   = s_q.scl[1];
        ev_o.scl_rise = s_q.scl[1] & ~s_q.scl[2];
        ev_o.scl_fall = ~s_q.scl[1] & s_q.scl[2];
        ev_o.sda      = s_q.sda[1];
        ev_o.start    = s_q.scl[1] & s_q.scl[2] & s_q.sda[2] & ~s_q.sda[1];
        ev_o.stop     = s_q.scl[1] & s_q.scl[2] & ~s_q.sda[2] & s_q.sda[1];
        ev_o.inhibit  = s_q.inh[1];
    end
endmodule

// File: rtl/i2c_mem_proto.sv
`timescale 1ns/1ps
module i2c_mem_proto
    import i2c_mem_pkg::*;
#(
    parameter int AW   = 8,
    parameter int PAGE = 4,
    localparam int PW  = $clog2(PAGE)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  bus_ev_t                       ev_i,
    input  logic [2:0]                    strap_i,
    input  logic                          busy_i,
    input  logic [BYTE_W-1:0]             rd_data_i,
    output logic [AW-1:0]                 rd_addr_o,
    output logic                          cmt_o,
    output logic [AW-PW-1:0]              cmt_base_o,
    output logic [PAGE-1:0]               cmt_vld_o,
    output logic [PAGE-1:0][BYTE_W-1:0]   cmt_data_o,
    output logic                          sda_oe_o
);
    typedef struct packed {
        phase_e                       ph;
        logic [3:0]                   cnt;
        logic [BYTE_W-1:0]            sh;
        logic [BYTE_W-1:0]            tx;
        logic                         oe;
        logic                         rw;
        logic                         mack;
        logic [AW-1:0]                ptr;
        logic [PAGE-1:0]              vld;
        logic [PAGE-1:0][BYTE_W-1:0]  pbuf;
    } st_t;

    st_t q, n;

    always_comb begin
        n     = q;
        cmt_o = 1'b0;
        if (ev_i.start) begin
            // repeated or fresh start drops any pending page
            n.ph  = PH_DEV;
            n.cnt = '0;
            n.oe  = 1'b0;
            n.vld = '0;
        end else if (ev_i.stop) begin
            cmt_o = |q.vld;
            n.ph  = PH_IDLE;
            n.oe  = 1'b0;
            n.vld = '0;
        end else if (ev_i.scl_rise) begin
            case (q.ph)
                PH_DEV, PH_WORD, PH_WR: begin
                    n.sh  = {q.sh[BYTE_W-2:0], ev_i.sda};
                    n.cnt = q.cnt + 4'd1;
                end
                PH_RD:     n.cnt  = q.cnt + 4'd1;
                PH_RD_ACK: n.mack = ~ev_i.sda;
                default: ;
            endcase
        end else if (ev_i.scl_fall) begin
            case (q.ph)
                PH_DEV: begin
                    if (q.cnt == 4'd8) begin
                        n.cnt = '0;
                        if (q.sh[7:1] == {DEV_CODE, strap_i} && !busy_i) begin
                            n.ph = PH_DEV_ACK;
                            n.oe = 1'b1;
                            n.rw = q.sh[0];
                        end else begin
                            n.ph = PH_IDLE;
                        end
                    end
                end
                PH_DEV_ACK: begin
                    if (q.rw) begin
                        n.ph = PH_RD;
                        n.tx = rd_data_i;
                        n.oe = ~rd_data_i[BYTE_W-1];
                    end else begin
                        n.ph = PH_WORD;
                        n.oe = 1'b0;
                    end
                end
                PH_WORD: begin
                    if (q.cnt == 4'd8) begin
                        n.cnt = '0;
                        n.ptr = q.sh[AW-1:0];
                        n.oe  = 1'b1;
                        n.ph  = PH_WORD_ACK;
                    end
                end
                PH_WORD_ACK: begin
                    n.oe = 1'b0;
                    n.ph = PH_WR;
                end
                PH_WR: begin
                    if (q.cnt == 4'd8) begin
                        n.cnt = '0;
                        n.oe  = 1'b1;
                        n.ph  = PH_WR_ACK;
                        if (!ev_i.inhibit) begin
                            n.pbuf[q.ptr[PW-1:0]] = q.sh;
                            n.vld[q.ptr[PW-1:0]]  = 1'b1;
                            n.ptr[PW-1:0]         = q.ptr[PW-1:0] + 1'b1;
                        end
                    end
                end
                PH_WR_ACK: begin
                    n.oe = 1'b0;
                    n.ph = PH_WR;
                end
                PH_RD: begin
                    if (q.cnt == 4'd8) begin
                        n.cnt = '0;
                        n.oe  = 1'b0;
                        n.ph  = PH_RD_ACK;
                        n.ptr = q.ptr + 1'b1;
                    end else begin
                        n.tx = {q.tx[BYTE_W-2:0], 1'b0};
                        n.oe = ~q.tx[BYTE_W-2];
                    end
                end
                PH_RD_ACK: begin
                    if (q.mack) begin
                        n.ph = PH_RD;
                        n.tx = rd_data_i;
                        n.oe = ~rd_data_i[BYTE_W-1];
                    end else begin
                        n.ph = PH_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign rd_addr_o  = q.ptr;
    assign cmt_base_o = q.ptr[AW-1:PW];
    assign cmt_vld_o  = q.vld;
    assign cmt_data_o = q.pbuf;
    assign sda_oe_o   = q.oe;

    AST_ADDR_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DEV_ACK && $past(q.ph) != PH_DEV_ACK) |-> !$past(busy_i)); // R6
    AST_PAGE_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_WR_ACK && $past(q.ph) == PH_WR) |-> q.ptr[AW-1:PW] == $past(q.ptr[AW-1:PW])); // R3
    AST_INHIBIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_WR_ACK && $past(q.ph) == PH_WR && $past(ev_i.inhibit))
        |-> (q.vld == $past(q.vld) && q.ptr == $past(q.ptr))); // R7
    AST_DRIVE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.ph inside {PH_DEV_ACK, PH_WORD_ACK, PH_WR_ACK, PH_RD})); // R2
    AST_READ_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RD && $past(q.ph) == PH_RD && ev_i.scl_hi && $past(ev_i.scl_hi))
        |-> $stable(q.oe)); // R9
endmodule

// File: rtl/i2c_mem_store.sv
`timescale 1ns/1ps
module i2c_mem_store
    import i2c_mem_pkg::*;
#(
    parameter int WORDS      = 256,
    parameter int PAGE       = 4,
    parameter int WRITE_CLKS = 400,
    localparam int AW        = $clog2(WORDS),
    localparam int PW        = $clog2(PAGE),
    localparam int TW        = $clog2(WRITE_CLKS + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmt_i,
    input  logic [AW-PW-1:0]             base_i,
    input  logic [PAGE-1:0]              vld_i,
    input  logic [PAGE-1:0][BYTE_W-1:0]  data_i,
    input  logic [AW-1:0]                rd_addr_i,
    output logic [BYTE_W-1:0]            rd_data_o,
    output logic                         busy_o
);
    typedef struct packed {
        logic [WORDS-1:0][BYTE_W-1:0] mem;
        logic [TW-1:0]                tmr;
    } st_t;

    st_t q, n;

    always_comb begin
        n = q;
        if (cmt_i) begin
            n.tmr = TW'(WRITE_CLKS);
            // whole page lands in one clock, masked by the slots filled
            for (int i = 0; i < PAGE; i++) begin
                if (vld_i[i]) begin
                    n.mem[{base_i, PW'(i)}] = data_i[i];
                end
            end
        end else if (q.tmr != '0) begin
            n.tmr = q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign rd_data_o = q.mem[rd_addr_i];
    assign busy_o    = (q.tmr != '0);

    AST_COMMIT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_i |-> !busy_o); // R6
    AST_CYCLE_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_i |=> busy_o); // R5
    AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_i |=> $stable(q.mem)); // R4
endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int WORDS      = 256,
    parameter int PAGE       = 4,
    parameter int WRITE_CLKS = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wr_inhibit_i,
    output logic       sda_oe_o,
    output logic       busy_o
);
    localparam int AW = $clog2(WORDS);
    localparam int PW = $clog2(PAGE);

    bus_ev_t                      ev;
    logic                         busy;
    logic [BYTE_W-1:0]            rd_data;
    logic [AW-1:0]                rd_addr;
    logic                         cmt;
    logic [AW-PW-1:0]             cmt_base;
    logic [PAGE-1:0]              cmt_vld;
    logic [PAGE-1:0][BYTE_W-1:0]  cmt_data;

    i2c_mem_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .inhibit_i (wr_inhibit_i),
        .ev_o      (ev)
    );

    i2c_mem_proto #(.AW(AW), .PAGE(PAGE)) u_proto (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .strap_i    (strap_i),
        .busy_i     (busy),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .cmt_o      (cmt),
        .cmt_base_o (cmt_base),
        .cmt_vld_o  (cmt_vld),
        .cmt_data_o (cmt_data),
        .sda_oe_o   (sda_oe_o)
    );

    i2c_mem_store #(.WORDS(WORDS), .PAGE(PAGE), .WRITE_CLKS(WRITE_CLKS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmt_i     (cmt),
        .base_i    (cmt_base),
        .vld_i     (cmt_vld),
        .data_i    (cmt_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .busy_o    (busy)
    );

    assign busy_o = busy;
endmodule

// File: tb/i2c_mem_slave_test.sv
`timescale 1ns/1ps
module i2c_mem_slave_test;
    localparam int WCLK = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       inh = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       busy;
    wire        sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_mem_slave #(.WORDS(256), .PAGE(4), .WRITE_CLKS(WCLK)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .strap_i      (strap),
        .wr_inhibit_i (inh),
        .sda_oe_o     (sda_oe),
        .busy_o       (busy)
    );

    int errors = 0;
    int checks = 0;
    int mem_m [256];
    int ptr_m = 0;
    int pend_a [$];
    int pend_d [$];
    int arm = 0;
    int busy_cnt = 0;
    bit live = 1'b0;

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference write-cycle window, stepped on every clock edge
    always @(posedge clk) begin
        if (arm > 0) begin
            arm--;
            if (arm == 0) busy_cnt = WCLK;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
    end

    always @(negedge clk) begin
        if (live) check("R5", busy, (busy_cnt > 0) ? 1 : 0, "busy per clock");
    end

    task automatic tick(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic put_bit(bit b);
        tick(1); sda_m = b; tick(5); scl_m = 1'b1; tick(6); scl_m = 1'b0;
    endtask

    task automatic get_bit(output bit b);
        tick(1); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(3); b = sda_line; tick(3); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        tick(1); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(6); sda_m = 1'b0; tick(6); scl_m = 1'b0;
        pend_a.delete();
        pend_d.delete();
    endtask

    task automatic bus_stop();
        tick(1); sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(6);
        sda_m = 1'b1;
        if (pend_a.size() > 0) begin
            foreach (pend_a[i]) mem_m[pend_a[i]] = pend_d[i];
            arm = 3;
            pend_a.delete();
            pend_d.delete();
        end
        tick(12);
    endtask

    task automatic send_byte(int b, bit exp_ack, string req);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        check(req, a, exp_ack ? 0 : 1, "acknowledge bit");
    endtask

    task automatic dev(bit rd, bit exp_ack, string req);
        send_byte({4'b1010, strap, rd}, exp_ack, req);
    endtask

    task automatic word(int a, string req);
        send_byte(a, 1'b1, req);
        ptr_m = a;
    endtask

    task automatic wr_data(int d, string req);
        if (!inh) begin
            pend_a.push_back(ptr_m);
            pend_d.push_back(d);
            ptr_m = (ptr_m & 8'hFC) | ((ptr_m + 1) & 3);
        end
        send_byte(d, 1'b1, req);
    endtask

    task automatic recv_byte(bit ack, string req, output int got);
        bit v;
        got = 0;
        for (int i = 7; i >= 0; i--) begin
            get_bit(v);
            got = (got << 1) | int'(v);
        end
        check(req, got, mem_m[ptr_m], "read byte");
        ptr_m = (ptr_m + 1) % 256;
        put_bit(!ack);
    endtask

    task automatic byte_write(int a, int d);
        bus_start(); dev(1'b0, 1'b1, "R1"); word(a, "R2"); wr_data(d, "R2"); bus_stop();
        tick(WCLK + 10);
    endtask

    task automatic rand_read(int a, bit ack, string req, output int got);
        bus_start(); dev(1'b0, 1'b1, "R1"); word(a, "R10");
        bus_start(); dev(1'b1, 1'b1, "R10");
        recv_byte(ack, req, got);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int got;
        foreach (mem_m[i]) mem_m[i] = 0;
        tick(4);
        rst_n = 1'b1;
        tick(3);
        live = 1'b1;
        // R12: idle outputs after reset
        check("R12", sda_oe, 0, "sda released");
        check("R12", busy, 0, "busy low");

        // R9 / R12: current-address read right after reset gives byte 0
        bus_start(); dev(1'b1, 1'b1, "R1"); recv_byte(1'b0, "R9", got); bus_stop();
        check("R12", got, 0, "byte zero after reset");

        // R1: foreign addresses are refused
        bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, 1'b0, "R1"); bus_stop();
        bus_start(); send_byte({4'b1011, strap, 1'b1}, 1'b0, "R1"); bus_stop();

        // R2 / R5: byte write then R6: address refused during the cycle
        bus_start(); dev(1'b0, 1'b1, "R1"); word(8'h10, "R2"); wr_data(8'hA5, "R2"); bus_stop();
        bus_start(); dev(1'b0, 1'b0, "R6"); bus_stop();
        bus_start(); dev(1'b1, 1'b0, "R6"); bus_stop();
        tick(WCLK + 10);

        // R10: random read
        rand_read(8'h10, 1'b0, "R10", got); bus_stop();
        check("R10", got, 8'hA5, "random read value");

        // R3 / R8: six bytes into page 0x20 starting at slot 2
        bus_start(); dev(1'b0, 1'b1, "R1"); word(8'h22, "R2");
        wr_data(8'h11, "R3"); wr_data(8'h22, "R3"); wr_data(8'h33, "R3");
        wr_data(8'h44, "R3"); wr_data(8'h55, "R3"); wr_data(8'h66, "R3");
        bus_stop();
        tick(WCLK + 10);
        bus_start(); dev(1'b1, 1'b1, "R1"); recv_byte(1'b0, "R8", got); bus_stop();
        check("R8", got, 8'h33, "pointer after page commit");

        // R11: sequential read across the page
        rand_read(8'h21, 1'b1, "R11", got);
        check("R3", got, 8'h44, "slot 1");
        recv_byte(1'b1, "R11", got);
        check("R3", got, 8'h55, "slot 2 overwritten");
        recv_byte(1'b0, "R11", got);
        check("R3", got, 8'h66, "slot 3 overwritten");
        bus_stop();

        // R11: wrap from 255 to 0
        byte_write(8'hFF, 8'h3C);
        byte_write(8'h00, 8'h81);
        byte_write(8'h41, 8'h99);
        rand_read(8'hFF, 1'b1, "R11", got);
        check("R11", got, 8'h3C, "last byte");
        recv_byte(1'b1, "R11", got);
        check("R11", got, 8'h81, "wrapped to zero");
        recv_byte(1'b0, "R11", got);
        bus_stop();
        check("R11", sda_oe, 0, "released after nack");

        // R7: inhibited write is acknowledged, dropped, pointer unmoved
        inh = 1'b1; tick(4);
        bus_start(); dev(1'b0, 1'b1, "R1"); word(8'h40, "R7");
        wr_data(8'h55, "R7"); wr_data(8'h56, "R7"); bus_stop();
        inh = 1'b0; tick(20);
        check("R7", busy, 0, "no write cycle");
        bus_start(); dev(1'b1, 1'b1, "R7"); recv_byte(1'b0, "R7", got); bus_stop();
        check("R7", got, 0, "pointer held at 0x40, store unchanged");

        // R4: repeated start discards buffered data
        bus_start(); dev(1'b0, 1'b1, "R1"); word(8'h50, "R4"); wr_data(8'h77, "R4");
        bus_start(); dev(1'b1, 1'b1, "R4"); recv_byte(1'b0, "R4", got); bus_stop();
        tick(20);
        check("R4", busy, 0, "no cycle after discard");
        rand_read(8'h50, 1'b0, "R4", got); bus_stop();
        check("R4", got, 0, "discarded byte not stored");

        tick(20);
        live = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule